// File: doc/BRIEF.md
# Windowed Average Occupancy Monitor

This block watches a set of buffer fill levels and reports how full each buffer was on average over fixed windows of time. On every clock out of reset it adds the present depth of each buffer into a running sum. A window is a power-of-two number of clock cycles. When a window closes, the block takes a copy of every sum, clears the sums so the next window begins at zero, and streams out one record per buffer. Each record carries the buffer index, the cycle count at which the window closed, the raw sum and the average depth as a fixed-point number.

Records leave over a valid/ready handshake, lowest index first. Accumulation never stalls for the output stream. If a new window closes before the consumer has taken every record of the previous one, the older records still waiting are dropped and the stream restarts with the new window. The window length is applied at window edges only. This means a change on the length input mid-window takes effect when the current window ends.

Top module: `occ_avg_monitor`

## Requirements
- R1: A clock edge with `rst_n` low clears every sum, the window counter and the cycle counter, and drives `rec_valid` low. The first window after reset counts from the first edge with `rst_n` high.
- R2: On each clock edge with `rst_n` high, the depth of buffer i, taken from `depth_flat[i*DEPTH_W +: DEPTH_W]`, is added to that buffer's sum.
- R3: A window lasts 2^k cycles, where k is `win_log2` limited to at most MAX_WIN_LOG2. k is sampled during reset and again at the end of each window, and that value governs the following window.
- R4: When a window ends, `rec_time` for its records equals the number of clock edges with `rst_n` high since reset, counted up to and including the window's last edge. `rec_time` changes only when a window ends.
- R5: `rec_sum` of the record for buffer i equals the sum of that buffer's depth samples over the 2^k edges of the window just ended.
- R6: `rec_avg` equals floor(rec_sum * 2^FRAC_W / 2^k), which is the average depth with FRAC_W fractional bits.
- R7: Every sum restarts from zero at the edge after a window's last edge. No sample is lost or counted twice while records are being streamed out.
- R8: Records appear in index order 0 to NUM_BUF-1, and each is consumed on an edge with `rec_valid` and `rec_ready` both high. While `rec_ready` is low, the index and contents hold. After the last index is accepted, `rec_valid` goes low until the next window ends.
- R9: A window that ends while records of the previous window are still unaccepted discards those records. The stream restarts at index 0 on the next cycle with the new window's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| win_log2 | input | LOG2_W | Base-2 logarithm of the window length in cycles |
| depth_flat | input | NUM_BUF*DEPTH_W | Packed present depth of every buffer |
| rec_valid | output | 1 | A record is offered |
| rec_ready | input | 1 | Consumer accepts the offered record |
| rec_idx | output | IDX_W | Buffer index of the record |
| rec_time | output | TS_W | Cycle count at the close of the record's window |
| rec_sum | output | SUM_W | Raw sum of depth samples over the window |
| rec_avg | output | AVG_W | Average depth, FRAC_W fractional bits |

## Verification
A sum that drops or repeats a sample shows in the `rec_sum` and `rec_avg` of the very next record for that buffer, at most one window later. A wrong window counter or a missed length update moves `rec_time` and the moment `rec_valid` rises, and this shows at the first window edge after the error. Faults in the streaming index or the hold logic show within a few cycles as records out of order, records that change while stalled, or a stream that fails to restart at index 0. The comparison runs on every cycle, so each of these is caught at the first cycle where the port values differ from the reference.

// File: rtl/occ_mon_pkg.sv
// Package: shared helpers for the occupancy monitor.
// Assumes callers pass widths that hold the clamp limit.
package occ_mon_pkg;

    // Limit a requested window exponent to the supported maximum.
    function automatic int unsigned clamp_exp(input int unsigned req, input int unsigned max_exp);
        return (req > max_exp) ? max_exp : req;
    endfunction

endpackage

// File: rtl/occ_window_timer.sv
// Window timer: counts cycles since reset and cycles inside the current window.
// It flags the last cycle of each window and holds the active window exponent.
// Assumes MAX_WIN_LOG2 >= 1 and LOG2_W wide enough to carry MAX_WIN_LOG2.
module occ_window_timer #(
    parameter int MAX_WIN_LOG2 = 6,
    parameter int LOG2_W       = 3,
    parameter int TS_W         = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOG2_W-1:0] win_log2_in,
    output logic              win_end,
    output logic [LOG2_W-1:0] cur_log2,
    output logic [TS_W-1:0]   cycle_now
);
    import occ_mon_pkg::*;

    localparam int CNT_W = MAX_WIN_LOG2;

    logic [CNT_W-1:0]  win_cnt;
    logic [CNT_W:0]    span;
    logic [CNT_W:0]    last_pos;
    logic [LOG2_W-1:0] req_log2;

    // Clamp the requested exponent to what the counter supports.
    always_comb begin
        req_log2 = LOG2_W'(clamp_exp(int'(win_log2_in), MAX_WIN_LOG2));
    end

    // Decode the last in-window count from the active exponent.
    always_comb begin
        span     = (CNT_W+1)'(1) << cur_log2;
        last_pos = span - (CNT_W+1)'(1);
        win_end  = (win_cnt == last_pos[CNT_W-1:0]);
    end

    // Advance the counters, closing and reloading the window at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt   <= '0;
            cycle_now <= '0;
            cur_log2  <= req_log2;
        end else begin
            cycle_now <= cycle_now + TS_W'(1);
            if (win_end) begin
                win_cnt  <= '0;
                cur_log2 <= req_log2;
            end else begin
                win_cnt  <= win_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/occ_accum.sv
// Accumulator bank: one running sum of depth samples per buffer.
// The updated total (sum plus present sample) is exported. A clear starts
// the next window from zero. Assumes SUM_W covers the largest window.
module occ_accum #(
    parameter int NUM_BUF = 4,
    parameter int DEPTH_W = 6,
    parameter int SUM_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic [NUM_BUF*DEPTH_W-1:0] depth_flat,
    output logic [NUM_BUF*SUM_W-1:0]   total_flat
);
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic [SUM_W-1:0] acc;
        logic [SUM_W-1:0] total;

        // Add this cycle's depth to the running sum.
        always_comb begin
            total = acc + SUM_W'(depth_flat[g*DEPTH_W +: DEPTH_W]);
        end

        // Keep the running sum, or restart it when the window closes.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) acc <= '0;
            else                 acc <= total;
        end

        assign total_flat[g*SUM_W +: SUM_W] = total;
    end
endmodule

// File: rtl/occ_drain.sv
// Result streamer: snapshots all window totals and offers them one index at a
// time over valid/ready. A new snapshot replaces an unfinished stream.
// Assumes NUM_BUF >= 2 and FRAC_W >= 1.
module occ_drain #(
    parameter int NUM_BUF = 4,
    parameter int SUM_W   = 12,
    parameter int LOG2_W  = 3,
    parameter int TS_W    = 24,
    parameter int FRAC_W  = 4,
    parameter int AVG_W   = 10,
    parameter int IDX_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_BUF*SUM_W-1:0] total_flat,
    input  logic [TS_W-1:0]          load_time,
    input  logic [LOG2_W-1:0]        load_log2,
    input  logic                     rec_ready,
    output logic                     rec_valid,
    output logic [IDX_W-1:0]         rec_idx,
    output logic [TS_W-1:0]          rec_time,
    output logic [SUM_W-1:0]         rec_sum,
    output logic [AVG_W-1:0]         rec_avg
);
    import occ_mon_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUF - 1);

    logic [SUM_W-1:0]        snap [NUM_BUF];
    logic [LOG2_W-1:0]       snap_log2;
    logic [SUM_W+FRAC_W-1:0] scaled;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_snap
        // Capture this buffer's window total at the window edge.
        always_ff @(posedge clk) begin
            if (!rst_n)    snap[g] <= '0;
            else if (load) snap[g] <= total_flat[g*SUM_W +: SUM_W];
        end
    end

    // Walk the indices; a fresh snapshot restarts the walk at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_idx   <= '0;
            rec_time  <= '0;
            snap_log2 <= '0;
        end else if (load) begin
            rec_valid <= 1'b1;
            rec_idx   <= '0;
            rec_time  <= load_time;
            snap_log2 <= load_log2;
        end else if (rec_valid && rec_ready) begin
            if (rec_idx == LAST_IDX) rec_valid <= 1'b0;
            else                     rec_idx   <= rec_idx + IDX_W'(1);
        end
    end

    // Present the selected sum and its fixed-point mean.
    always_comb begin
        rec_sum = snap[rec_idx];
        scaled  = {rec_sum, {FRAC_W{1'b0}}} >> snap_log2;
        rec_avg = AVG_W'(scaled);
    end
endmodule

// File: rtl/occ_avg_monitor.sv
// Top: windowed average occupancy monitor. Ties the timer, the accumulator
// bank and the result streamer together. Assumes the parameter limits stated
// in each submodule.
module occ_avg_monitor #(
    parameter int NUM_BUF      = 4,
    parameter int DEPTH_W      = 6,
    parameter int MAX_WIN_LOG2 = 6,
    parameter int FRAC_W       = 4,
    parameter int TS_W         = 24,
    localparam int LOG2_W      = $clog2(MAX_WIN_LOG2 + 1),
    localparam int SUM_W       = DEPTH_W + MAX_WIN_LOG2,
    localparam int AVG_W       = DEPTH_W + FRAC_W,
    localparam int IDX_W       = $clog2(NUM_BUF)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LOG2_W-1:0]          win_log2,
    input  logic [NUM_BUF*DEPTH_W-1:0] depth_flat,
    output logic                       rec_valid,
    input  logic                       rec_ready,
    output logic [IDX_W-1:0]           rec_idx,
    output logic [TS_W-1:0]            rec_time,
    output logic [SUM_W-1:0]           rec_sum,
    output logic [AVG_W-1:0]           rec_avg
);
    logic                     win_end;
    logic [LOG2_W-1:0]        cur_log2;
    logic [TS_W-1:0]          cycle_now;
    logic [NUM_BUF*SUM_W-1:0] total_flat;
    logic [TS_W-1:0]          end_time;

    // Window close time is the count including the closing edge.
    always_comb begin
        end_time = cycle_now + TS_W'(1);
    end

    occ_window_timer #(
        .MAX_WIN_LOG2(MAX_WIN_LOG2), .LOG2_W(LOG2_W), .TS_W(TS_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .win_log2_in(win_log2),
        .win_end(win_end), .cur_log2(cur_log2), .cycle_now(cycle_now)
    );

    occ_accum #(
        .NUM_BUF(NUM_BUF), .DEPTH_W(DEPTH_W), .SUM_W(SUM_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .clear(win_end),
        .depth_flat(depth_flat), .total_flat(total_flat)
    );

    occ_drain #(
        .NUM_BUF(NUM_BUF), .SUM_W(SUM_W), .LOG2_W(LOG2_W), .TS_W(TS_W),
        .FRAC_W(FRAC_W), .AVG_W(AVG_W), .IDX_W(IDX_W)
    ) u_drain (
        .clk(clk), .rst_n(rst_n), .load(win_end), .total_flat(total_flat),
        .load_time(end_time), .load_log2(cur_log2), .rec_ready(rec_ready),
        .rec_valid(rec_valid), .rec_idx(rec_idx), .rec_time(rec_time),
        .rec_sum(rec_sum), .rec_avg(rec_avg)
    );
endmodule

// File: rtl/occ_avg_monitor_chk.sv
// Checker: handshake and timing properties of the monitor's record stream.
// Attached to every occ_avg_monitor instance through the bind below.
module occ_avg_monitor_chk #(
    parameter int NUM_BUF = 4,
    parameter int SUM_W   = 12,
    parameter int TS_W    = 24,
    parameter int IDX_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             win_end,
    input logic             rec_valid,
    input logic             rec_ready,
    input logic [IDX_W-1:0] rec_idx,
    input logic [TS_W-1:0]  rec_time,
    input logic [SUM_W-1:0] rec_sum
);
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !rec_valid)
        else $error("reset did not idle the stream");

    p_time_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(rec_time))
        else $error("timestamp moved without a window end");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready && !win_end) |=>
            (rec_valid && $stable(rec_idx) && $stable(rec_sum)))
        else $error("stalled record changed");

    p_drain_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_ready && rec_idx == IDX_W'(NUM_BUF - 1) && !win_end) |=> !rec_valid)
        else $error("stream did not stop after last index");

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (rec_valid && rec_idx == '0))
        else $error("stream did not restart at index 0");
endmodule

bind occ_avg_monitor occ_avg_monitor_chk #(
    .NUM_BUF(NUM_BUF), .SUM_W(SUM_W), .TS_W(TS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .win_end(win_end), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_idx(rec_idx), .rec_time(rec_time), .rec_sum(rec_sum)
);

// File: tb/tb_occ_avg_monitor.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped once per clock and compared
// with the ports at every falling edge.
module tb_occ_avg_monitor;
    localparam int NUM_BUF      = 4;
    localparam int DEPTH_W      = 6;
    localparam int MAX_WIN_LOG2 = 6;
    localparam int FRAC_W       = 4;
    localparam int TS_W         = 24;
    localparam int LOG2_W       = $clog2(MAX_WIN_LOG2 + 1);
    localparam int SUM_W        = DEPTH_W + MAX_WIN_LOG2;
    localparam int AVG_W        = DEPTH_W + FRAC_W;
    localparam int IDX_W        = $clog2(NUM_BUF);

    logic                       clk = 1'b0;
    logic                       rst_n;
    logic [LOG2_W-1:0]          win_log2;
    logic [NUM_BUF*DEPTH_W-1:0] depth_flat;
    logic                       rec_valid;
    logic                       rec_ready;
    logic [IDX_W-1:0]           rec_idx;
    logic [TS_W-1:0]            rec_time;
    logic [SUM_W-1:0]           rec_sum;
    logic [AVG_W-1:0]           rec_avg;

    always #2.5 clk = ~clk;

    occ_avg_monitor #(
        .NUM_BUF(NUM_BUF), .DEPTH_W(DEPTH_W), .MAX_WIN_LOG2(MAX_WIN_LOG2),
        .FRAC_W(FRAC_W), .TS_W(TS_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .win_log2(win_log2), .depth_flat(depth_flat),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_idx(rec_idx),
        .rec_time(rec_time), .rec_sum(rec_sum), .rec_avg(rec_avg)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string phase = "R1";
    bit    done  = 1'b0;

    // Reference model state
    longint m_acc  [NUM_BUF];
    longint m_snap [NUM_BUF];
    int     m_cnt = 0, m_log2 = 0, m_slog2 = 0, m_idx = 0;
    longint m_cyc = 0, m_time = 0;
    bit     m_valid = 1'b0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (phase %s) %s: actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R8", "rec_valid", longint'(rec_valid), longint'(m_valid));
        if (m_valid && rec_valid) begin
            chk("R8", "rec_idx",  longint'(rec_idx),  longint'(m_idx));
            chk("R4", "rec_time", longint'(rec_time), m_time);
            chk("R5", "rec_sum",  longint'(rec_sum),  m_snap[m_idx]);
            chk("R6", "rec_avg",  longint'(rec_avg),
                (m_snap[m_idx] * (longint'(1) << FRAC_W)) >> m_slog2);
        end
    endtask

    function automatic int clamp(input int v);
        return (v > MAX_WIN_LOG2) ? MAX_WIN_LOG2 : v;
    endfunction

    // One cycle: compare, drive new inputs, advance the model as the edge will.
    task automatic step(input bit rst_v, input int wl, input int rdy_pct, input bit rnd);
        int  d [NUM_BUF];
        bit  rdy;
        bit  wend;
        @(negedge clk);
        compare();
        rdy = ($urandom_range(0, 99) < rdy_pct);
        for (int i = 0; i < NUM_BUF; i++) begin
            d[i] = rnd ? int'($urandom_range(0, (1 << DEPTH_W) - 1)) : (i + 1);
            depth_flat[i*DEPTH_W +: DEPTH_W] = DEPTH_W'(d[i]);
        end
        rst_n     = rst_v;
        win_log2  = LOG2_W'(wl);
        rec_ready = rdy;
        if (!rst_v) begin
            for (int i = 0; i < NUM_BUF; i++) begin m_acc[i] = 0; m_snap[i] = 0; end
            m_cnt = 0; m_cyc = 0; m_time = 0; m_idx = 0; m_valid = 1'b0; m_slog2 = 0;
            m_log2 = clamp(wl);
        end else begin
            wend = (m_cnt == (1 << m_log2) - 1);
            for (int i = 0; i < NUM_BUF; i++) begin
                if (wend) begin m_snap[i] = m_acc[i] + d[i]; m_acc[i] = 0; end
                else          m_acc[i] = m_acc[i] + d[i];
            end
            if (wend) begin
                m_valid = 1'b1; m_idx = 0; m_time = m_cyc + 1; m_slog2 = m_log2;
            end else if (m_valid && rdy) begin
                if (m_idx == NUM_BUF - 1) m_valid = 1'b0;
                else                      m_idx++;
            end
            if (wend) begin m_cnt = 0; m_log2 = clamp(wl); end
            else      m_cnt++;
            m_cyc++;
        end
    endtask

    initial begin
        rst_n = 1'b0; win_log2 = '0; rec_ready = 1'b0; depth_flat = '0;
        for (int i = 0; i < NUM_BUF; i++) begin m_acc[i] = 0; m_snap[i] = 0; end
        phase = "R1"; repeat (3) step(1'b0, 2, 100, 1'b0);
        phase = "R2"; repeat (40) step(1'b1, 2, 100, 1'b0);
        phase = "R6"; repeat (300) step(1'b1, 3, 60, 1'b1);
        phase = "R3"; repeat (300) step(1'b1, 7, 80, 1'b1);
        repeat (100) step(1'b1, 1, 100, 1'b1);
        phase = "R9"; repeat (80) step(1'b1, 2, 15, 1'b1);
        phase = "R1"; repeat (3) step(1'b0, 0, 100, 1'b1);
        repeat (20) step(1'b1, 0, 100, 1'b1);
        phase = "R7";
        for (int k = 0; k < 3000; k++) step(1'b1, int'($urandom_range(0, 7)), 70, 1'b1);
        @(negedge clk); compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog (phase %s): actual=timeout expected=finish", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule